// File: doc/BRIEF.md
# Privilege and exception sequencing unit

This unit owns the program counter, the saved program counter and the privilege bit of a small processor. On every cycle in which the processor presents an instruction (`step` high), it looks at every hazard that instruction can raise at once: a pending clock interrupt, a user-mode fetch below the reserved boundary, a trap instruction, a user-mode write to the privilege bit, and user-mode operand addresses below the boundary. If any hazard is present, the unit redirects control to a fixed vector and enters system mode. If none is present, it advances the program counter by one instruction.

A return-from-exception strobe exchanges the program counter and the saved program counter and drops to user mode, all in one cycle. The redirect flag, the cause code and the interrupt acknowledge are combinational and valid during the cycle in which the redirect is decided. The new program counter appears after the next clock edge.

Top module: `priv_seq`

## Requirements
- R1: After reset, `pc` is 0, `epc` is 0 and `mode` is 0 (system), and no redirect is reported.
- R2: A step that raises no hazard and is not a return advances `pc` by 4, modulo 2^AW, and leaves `epc` unchanged.
- R3: In user mode (`mode`=1), a step whose `pc` is below RESV (default 100) redirects to vector 60 with cause 0.
- R4: In user mode, a step redirects to vector 60 with cause 0 when any enabled operand address is below RESV. `op_en` bit 0 enables `op_a`, bit 1 enables `op_b` and bit 2 enables `op_ind`. Disabled operands are ignored, and in system mode operand addresses are not checked.
- R5: A step with `dst_mode` in user mode redirects to vector 64 with cause 1. In system mode it loads `mode` from `mode_wdata` and advances `pc` by 4.
- R6: A step with `is_trap` redirects to vector 68 with cause 2 in either mode.
- R7: A step with `irq` high redirects to vector 72 with cause 3, and `irq_ack` is high in that cycle only.
- R8: On every redirect, `epc` receives the old `pc`, `pc` receives 60 + 4×cause and `mode` becomes 0.
- R9: When several hazards occur in one step, the redirect goes to the first present in this order: interrupt, fetch violation, trap, mode violation, operand violation. Any hazard takes precedence over `rte`.
- R10: A step with `rte` and no hazard loads `pc` from `epc`, loads `epc` from `pc` and sets `mode` to 1.
- R11: With `step` low, `pc`, `epc` and `mode` hold, and `redirect` and `irq_ack` stay low, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | Instruction presented this cycle |
| irq | input | 1 | Clock interrupt line |
| is_trap | input | 1 | Decoded trap instruction |
| dst_mode | input | 1 | Instruction writes the privilege bit |
| mode_wdata | input | 1 | Value written to the privilege bit |
| rte | input | 1 | Return-from-exception strobe |
| op_en | input | 3 | Operand enables: bit0 op_a, bit1 op_b, bit2 op_ind |
| op_a | input | AW | First operand address |
| op_b | input | AW | Second operand address |
| op_ind | input | AW | Address reached through an indirect load |
| pc | output | AW | Program counter |
| epc | output | AW | Saved program counter |
| mode | output | 1 | Privilege bit, 1 = user |
| redirect | output | 1 | Vector taken this cycle |
| cause | output | 2 | 0 memory, 1 mode, 2 trap, 3 interrupt |
| irq_ack | output | 1 | Timer reset pulse |

## Verification
The bench builds the unit with its default values: AW = 8, RESV = 100 and vector base 60. With these values every word-aligned fetch address and every possible operand address fits in a full sweep. Each of the 64 aligned program counters is reached in system mode by counting up, then entered in user mode through a trap and a return, so the fetch boundary at 96/100 and the wrap at 252 are both covered. Each of the 256 operand addresses is tried in each of the three operand slots. The priority order and the return swap are covered by hand-picked combinations of hazards.

// File: rtl/priv_seq.sv
module priv_seq #(
  parameter int AW       = 8,
  parameter int RESV     = 100,
  parameter int VEC_BASE = 60,
  parameter int ILEN     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          irq,
  input  logic          is_trap,
  input  logic          dst_mode,
  input  logic          mode_wdata,
  input  logic          rte,
  input  logic [2:0]    op_en,
  input  logic [AW-1:0] op_a,
  input  logic [AW-1:0] op_b,
  input  logic [AW-1:0] op_ind,
  output logic [AW-1:0] pc,
  output logic [AW-1:0] epc,
  output logic          mode,
  output logic          redirect,
  output logic [1:0]    cause,
  output logic          irq_ack
);
  localparam logic [AW-1:0] LIMIT = AW'(RESV);
  localparam logic [AW-1:0] VBASE = AW'(VEC_BASE);
  localparam logic [AW-1:0] INC   = AW'(ILEN);

  logic [AW-1:0] pc_q, epc_q;
  logic          mode_q;
  logic          hit;
  logic [AW-1:0] vec;

  wire fetch_bad = mode_q && (pc_q < LIMIT);
  wire oper_bad  = mode_q && ((op_en[0] && op_a < LIMIT) ||
                              (op_en[1] && op_b < LIMIT) ||
                              (op_en[2] && op_ind < LIMIT));
  wire mode_bad  = mode_q && dst_mode;

  always_comb begin
    hit   = 1'b1;
    cause = 2'd0;
    if (irq)            cause = 2'd3;
    else if (fetch_bad) cause = 2'd0;
    else if (is_trap)   cause = 2'd2;
    else if (mode_bad)  cause = 2'd1;
    else if (oper_bad)  cause = 2'd0;
    else                hit   = 1'b0;
  end

  assign vec      = VBASE + AW'({cause, 2'b00});
  assign redirect = step && hit;
  assign irq_ack  = step && irq;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q   <= '0;
      epc_q  <= '0;
      mode_q <= 1'b0;
    end else if (redirect) begin
      epc_q  <= pc_q;
      pc_q   <= vec;
      mode_q <= 1'b0;
    end else if (step && rte) begin
      pc_q   <= epc_q;
      epc_q  <= pc_q;
      mode_q <= 1'b1;
    end else if (step) begin
      pc_q <= pc_q + INC;
      if (dst_mode) mode_q <= mode_wdata;
    end
  end

  assign pc   = pc_q;
  assign epc  = epc_q;
  assign mode = mode_q;
endmodule

module priv_seq_chk #(
  parameter int AW       = 8,
  parameter int RESV     = 100,
  parameter int VEC_BASE = 60
) (
  input logic          clk,
  input logic          rst_n,
  input logic          step,
  input logic          irq,
  input logic          is_trap,
  input logic          dst_mode,
  input logic          rte,
  input logic [AW-1:0] pc,
  input logic [AW-1:0] epc,
  input logic          mode,
  input logic          redirect,
  input logic [1:0]    cause,
  input logic          irq_ack
);
  localparam logic [AW-1:0] LIMIT = AW'(RESV);
  localparam logic [AW-1:0] VBASE = AW'(VEC_BASE);
  localparam logic [AW-1:0] INC   = AW'(4);

  assert_vector_R8: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> (mode == 1'b0) && (epc == $past(pc)) &&
                 (pc == VBASE + AW'({$past(cause), 2'b00})));

  assert_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> redirect && (cause == 2'd3));

  assert_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && mode && pc < LIMIT) |-> redirect);

  assert_trap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && is_trap && !irq && !(mode && pc < LIMIT)) |-> redirect && (cause == 2'd2));

  assert_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !redirect && !rte) |=> (pc == $past(pc) + INC) && $stable(epc));

  assert_swap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !redirect && rte) |=> (pc == $past(epc)) && (epc == $past(pc)) && mode);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(pc) && $stable(epc) && $stable(mode));

  assert_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !step |-> !redirect && !irq_ack);
endmodule

bind priv_seq priv_seq_chk #(.AW(AW), .RESV(RESV), .VEC_BASE(VEC_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .step(step), .irq(irq), .is_trap(is_trap),
  .dst_mode(dst_mode), .rte(rte), .pc(pc), .epc(epc), .mode(mode),
  .redirect(redirect), .cause(cause), .irq_ack(irq_ack)
);

// File: tb/priv_seq_bench.sv
module priv_seq_bench;
  localparam int PERIOD = 10;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step = 0, irq = 0, is_trap = 0, dst_mode = 0, mode_wdata = 0, rte = 0;
  logic [2:0] op_en = '0;
  logic [AW-1:0] op_a = '0, op_b = '0, op_ind = '0;
  logic [AW-1:0] pc, epc;
  logic mode, redirect, irq_ack;
  logic [1:0] cause;

  int checks = 0, fails = 0;
  logic s_red, s_ack;
  logic [1:0] s_cause;

  always #(PERIOD/2) clk = ~clk;

  priv_seq u_priv_seq (
    .clk(clk), .rst_n(rst_n), .step(step), .irq(irq), .is_trap(is_trap),
    .dst_mode(dst_mode), .mode_wdata(mode_wdata), .rte(rte), .op_en(op_en),
    .op_a(op_a), .op_b(op_b), .op_ind(op_ind), .pc(pc), .epc(epc),
    .mode(mode), .redirect(redirect), .cause(cause), .irq_ack(irq_ack)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_in();
    step = 0; irq = 0; is_trap = 0; dst_mode = 0; mode_wdata = 0; rte = 0;
    op_en = '0; op_a = '0; op_b = '0; op_ind = '0;
  endtask

  // inputs already set at a negedge; sample combinational, then move to next negedge
  task automatic cyc();
    #1;
    s_red = redirect; s_cause = cause; s_ack = irq_ack;
    @(posedge clk);
    @(negedge clk);
    clear_in();
  endtask

  task automatic do_reset();
    clear_in();
    rst_n = 0;
    @(posedge clk); @(negedge clk);
    rst_n = 1;
  endtask

  task automatic plain();
    step = 1; cyc();
  endtask

  task automatic goto_user(input int target);
    do_reset();
    for (int i = 0; i < target / 4; i++) plain();
    step = 1; is_trap = 1; cyc();
    step = 1; rte = 1; cyc();
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
    $finish;
  end

  initial begin
    do_reset();
    #1;
    chk("R1 pc", pc, 0); chk("R1 epc", epc, 0); chk("R1 mode", mode, 0);
    chk("R1 redirect", redirect, 0);
    @(negedge clk);

    // R3 / R2 / R6 / R10 / R8: every aligned fetch address in user mode
    for (int k = 0; k < 64; k++) begin
      do_reset();
      for (int i = 0; i < k; i++) plain();
      chk("R2 count", pc, 4 * k);
      step = 1; is_trap = 1; cyc();
      chk("R6 redirect", s_red, 1); chk("R6 cause", s_cause, 2);
      chk("R8 pc", pc, 68); chk("R8 epc", epc, 4 * k); chk("R8 mode", mode, 0);
      step = 1; rte = 1; cyc();
      chk("R10 pc", pc, 4 * k); chk("R10 epc", epc, 68); chk("R10 mode", mode, 1);
      plain();
      if (4 * k < 100) begin
        chk("R3 redirect", s_red, 1); chk("R3 cause", s_cause, 0);
        chk("R3 pc", pc, 60); chk("R3 epc", epc, 4 * k); chk("R3 mode", mode, 0);
      end else begin
        chk("R2 redirect", s_red, 0);
        chk("R2 pc", pc, (4 * k + 4) % 256); chk("R2 epc", epc, 68); chk("R2 mode", mode, 1);
      end
    end

    // R4: every operand address in each slot, user mode
    begin
      int cur;
      goto_user(200); cur = 200;
      for (int a = 0; a < 256; a++) begin
        for (int s = 0; s < 3; s++) begin
          if (cur > 240) begin goto_user(200); cur = 200; end
          step = 1; op_en = 3'(1 << s);
          if (s == 0) op_a = 8'(a); else if (s == 1) op_b = 8'(a); else op_ind = 8'(a);
          cyc();
          if (a < 100) begin
            chk("R4 redirect", s_red, 1); chk("R4 cause", s_cause, 0);
            chk("R4 pc", pc, 60); chk("R4 epc", epc, cur);
            step = 1; rte = 1; cyc();
            chk("R10 back", pc, cur);
          end else begin
            chk("R4 no redirect", s_red, 0);
            cur += 4;
            chk("R4 pc", pc, cur); chk("R4 mode", mode, 1);
          end
        end
      end
    end

    // R4: disabled operands ignored, system mode unchecked
    goto_user(200);
    step = 1; op_en = 3'b000; op_a = 0; op_b = 0; op_ind = 0; cyc();
    chk("R4 disabled", s_red, 0); chk("R4 disabled pc", pc, 204);
    do_reset();
    step = 1; op_en = 3'b111; cyc();
    chk("R4 system", s_red, 0); chk("R4 system pc", pc, 4); chk("R4 system mode", mode, 0);

    // R5
    goto_user(200);
    step = 1; dst_mode = 1; mode_wdata = 1; cyc();
    chk("R5 user redirect", s_red, 1); chk("R5 user cause", s_cause, 1);
    chk("R5 user pc", pc, 64); chk("R5 user epc", epc, 200); chk("R5 user mode", mode, 0);
    do_reset();
    step = 1; dst_mode = 1; mode_wdata = 1; cyc();
    chk("R5 sys redirect", s_red, 0); chk("R5 sys pc", pc, 4); chk("R5 sys mode", mode, 1);

    // R6 in user mode
    goto_user(200);
    step = 1; is_trap = 1; cyc();
    chk("R6 user cause", s_cause, 2); chk("R6 user pc", pc, 68); chk("R6 user mode", mode, 0);

    // R7
    do_reset();
    step = 1; irq = 1; cyc();
    chk("R7 redirect", s_red, 1); chk("R7 cause", s_cause, 3); chk("R7 ack", s_ack, 1);
    chk("R7 pc", pc, 72); chk("R7 epc", epc, 0);
    plain();
    chk("R7 ack low", s_ack, 0); chk("R7 pc next", pc, 76);

    // R9 priority
    goto_user(20);
    step = 1; irq = 1; is_trap = 1; dst_mode = 1; op_en = 3'b001; cyc();
    chk("R9 irq first", s_cause, 3); chk("R9 irq pc", pc, 72);
    goto_user(20);
    step = 1; is_trap = 1; dst_mode = 1; op_en = 3'b001; cyc();
    chk("R9 fetch over trap", s_cause, 0); chk("R9 fetch pc", pc, 60);
    goto_user(200);
    step = 1; is_trap = 1; dst_mode = 1; op_en = 3'b001; cyc();
    chk("R9 trap over mode", s_cause, 2); chk("R9 trap pc", pc, 68);
    goto_user(200);
    step = 1; dst_mode = 1; op_en = 3'b001; cyc();
    chk("R9 mode over oper", s_cause, 1); chk("R9 mode pc", pc, 64);
    goto_user(200);
    step = 1; rte = 1; op_en = 3'b010; cyc();
    chk("R9 oper over rte", s_red, 1); chk("R9 rte pc", pc, 60); chk("R9 rte epc", epc, 200);
    chk("R9 rte mode", mode, 0);

    // R11
    goto_user(200);
    for (int i = 0; i < 3; i++) begin
      step = 0; irq = 1; is_trap = 1; rte = 1; dst_mode = 1; op_en = 3'b111;
      cyc();
      chk("R11 redirect", s_red, 0); chk("R11 ack", s_ack, 0);
      chk("R11 pc", pc, 200); chk("R11 epc", epc, 68); chk("R11 mode", mode, 1);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule